// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This block is the trap logic that sits beside the control sequencer of a multicycle processor. It holds the saved program counter, the trap reason and the enable mask stack. It watches three synchronous fault flags from the datapath: arithmetic overflow, an undecodable instruction and a system call. It also watches one external interrupt request line. In the cycle an enabled event is present it asks the sequencer to redirect fetch to a single fixed handler vector. On that same clock edge it saves the current PC, records a 2-bit reason code and pushes the enable nibble one position up the mask stack.

A return strobe from the sequencer pops the mask stack and redirects fetch to the saved PC. Handler software reaches the three registers through a small read/write port addressed by register number, which serves the move-to and move-from operations. The external request is only considered at the instruction-boundary strobe, so a device keeps its line high until the acknowledge pulse tells it the request was taken.

Top module: `trap_unit`

## Requirements
- R1: After reset, register 12 (mask) reads 0x0000000F, register 13 (reason) reads 0 and register 14 (saved PC) reads 0.
- R2: When several enabled events are present in one cycle, overflow is taken before invalid instruction, invalid instruction before syscall, and syscall before external interrupt.
- R3: Mask bit 3 enables the external interrupt, bit 2 invalid instruction, bit 1 overflow and bit 0 syscall. An event whose bit is 0 causes no redirect and changes no register.
- R4: In the cycle an event is taken, `redirect_o` is 1 and `target_o` is the handler vector 0x00000004. On the next edge the saved PC takes `pc_i`, the reason takes the event code and the mask shifts left by 4. The codes are 00 for interrupt, 01 for invalid instruction, 10 for overflow and 11 for syscall.
- R5: The interrupt request is taken only in a cycle where `step_done_i` is 1. A request held through cycles without the strobe is taken at the first strobe.
- R6: `iack_o` is a one-cycle pulse, high only in the cycle an external interrupt is taken.
- R7: A return strobe with no event taken gives `redirect_o`=1 and `target_o` equal to the saved PC, and shifts the mask right by 4 with zero fill. When nothing is redirected, `target_o` shows the saved PC.
- R8: Registers 12, 13 and 14 are read combinationally on `csr_rdata_o` and written on the edge when `csr_we_i` is 1. Any other register number reads 0, and a write to it has no effect.
- R9: Bits 31:2 of register 13 always read 0, even after a write of all ones.
- R10: When an event is taken, a register write and a return strobe in the same cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | PC of the current instruction |
| step_done_i | input | 1 | Instruction-boundary strobe |
| ovf_i | input | 1 | Arithmetic overflow flag |
| bad_op_i | input | 1 | Invalid-instruction flag |
| sys_i | input | 1 | System-call flag |
| irq_i | input | 1 | External interrupt request |
| eret_i | input | 1 | Return-from-trap strobe |
| csr_we_i | input | 1 | Register write enable |
| csr_addr_i | input | 5 | Register number |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data |
| redirect_o | output | 1 | Fetch redirect request |
| target_o | output | 32 | Redirect target PC |
| iack_o | output | 1 | Interrupt acknowledge pulse |

## Verification
Some rules are checked by assertions on every cycle. These are the shift of the mask stack on entry and on return, the upper reason bits reading zero, the acknowledge appearing only with an enabled request at a boundary, the acknowledge lasting one cycle, and a present, enabled overflow always redirecting to the vector. Other behaviour can only be shown by the bench scenarios. This covers the full priority order among simultaneous events, the exact reason codes and saved PC values, and a held request waiting for the boundary strobe. It also covers writes to unused numbers being dropped, and an event overriding a write and a return in the same cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    CODE_IRQ = 2'b00,
    CODE_BAD = 2'b01,
    CODE_OVF = 2'b10,
    CODE_SYS = 2'b11
  } trap_code_e;

  // Position of each enable bit within the live mask nibble
  localparam int MASK_IRQ = 3;
  localparam int MASK_BAD = 2;
  localparam int MASK_OVF = 1;
  localparam int MASK_SYS = 0;

  // Priority slots, index 0 is the most urgent
  localparam int SLOT_OVF = 0;
  localparam int SLOT_BAD = 1;
  localparam int SLOT_SYS = 2;
  localparam int SLOT_IRQ = 3;
  localparam int NUM_SRC  = 4;
endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/trap_csr.sv
module trap_csr
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  parameter int NIB  = 4,
  parameter logic [AW-1:0]   ADDR_MASK  = 5'd12,
  parameter logic [AW-1:0]   ADDR_WHY   = 5'd13,
  parameter logic [AW-1:0]   ADDR_SAVE  = 5'd14,
  parameter logic [XLEN-1:0] MASK_RESET = 32'h0000_000F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  trap_code_e      code_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            ret_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] mask_o,
  output logic [XLEN-1:0] save_o
);
  localparam int CW = 2;

  logic [XLEN-1:0] mask_q, mask_d;
  logic [XLEN-1:0] save_q, save_d;
  logic [CW-1:0]   why_q,  why_d;
  logic            mask_en, save_en, why_en;
  logic            wr_ok;

  assign wr_ok = we_i && !take_i;

  always_comb begin
    mask_en = 1'b0;
    mask_d  = mask_q;
    if (take_i) begin
      mask_en = 1'b1;
      mask_d  = mask_q << NIB;
    end else if (ret_i) begin
      mask_en = 1'b1;
      mask_d  = mask_q >> NIB;
    end else if (wr_ok && addr_i == ADDR_MASK) begin
      mask_en = 1'b1;
      mask_d  = wdata_i;
    end
  end

  always_comb begin
    save_en = 1'b0;
    save_d  = save_q;
    if (take_i) begin
      save_en = 1'b1;
      save_d  = pc_i;
    end else if (wr_ok && addr_i == ADDR_SAVE) begin
      save_en = 1'b1;
      save_d  = wdata_i;
    end
  end

  always_comb begin
    why_en = 1'b0;
    why_d  = why_q;
    if (take_i) begin
      why_en = 1'b1;
      why_d  = code_i;
    end else if (wr_ok && addr_i == ADDR_WHY) begin
      why_en = 1'b1;
      why_d  = wdata_i[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RESET;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       save_q <= '0;
    else if (save_en) save_q <= save_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      why_q <= '0;
    else if (why_en) why_q <= why_d;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_MASK)      rdata_o = mask_q;
    else if (addr_i == ADDR_WHY)  rdata_o = {{(XLEN-CW){1'b0}}, why_q};
    else if (addr_i == ADDR_SAVE) rdata_o = save_q;
  end

  assign mask_o = mask_q;
  assign save_o = save_q;
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  parameter logic [XLEN-1:0] VECTOR = 32'h0000_0004
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_i,
  input  logic            step_done_i,
  input  logic            ovf_i,
  input  logic            bad_op_i,
  input  logic            sys_i,
  input  logic            irq_i,
  input  logic            eret_i,
  input  logic            csr_we_i,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o,
  output logic            iack_o
);
  logic [XLEN-1:0]    mask_w, save_w;
  logic [NUM_SRC-1:0] req_w, grant_w;
  logic               take_w, ret_w;
  trap_code_e         code_w;

  always_comb begin
    req_w           = '0;
    req_w[SLOT_OVF] = ovf_i    && mask_w[MASK_OVF];
    req_w[SLOT_BAD] = bad_op_i && mask_w[MASK_BAD];
    req_w[SLOT_SYS] = sys_i    && mask_w[MASK_SYS];
    req_w[SLOT_IRQ] = irq_i    && step_done_i && mask_w[MASK_IRQ];
  end

  trap_prio #(.N(NUM_SRC)) u_prio (
    .req_i   (req_w),
    .grant_o (grant_w),
    .any_o   (take_w)
  );

  always_comb begin
    code_w = CODE_IRQ;
    if (grant_w[SLOT_OVF])      code_w = CODE_OVF;
    else if (grant_w[SLOT_BAD]) code_w = CODE_BAD;
    else if (grant_w[SLOT_SYS]) code_w = CODE_SYS;
  end

  assign ret_w = eret_i && !take_w;

  trap_csr #(.XLEN(XLEN), .AW(AW)) u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take_w),
    .code_i  (code_w),
    .pc_i    (pc_i),
    .ret_i   (ret_w),
    .we_i    (csr_we_i),
    .addr_i  (csr_addr_i),
    .wdata_i (csr_wdata_i),
    .rdata_o (csr_rdata_o),
    .mask_o  (mask_w),
    .save_o  (save_w)
  );

  assign redirect_o = take_w || ret_w;
  assign target_o   = take_w ? VECTOR : save_w;
  assign iack_o     = grant_w[SLOT_IRQ];
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  parameter logic [XLEN-1:0] VECTOR = 32'h0000_0004
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_done_i,
  input logic            ovf_i,
  input logic            irq_i,
  input logic [AW-1:0]   csr_addr_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o,
  input logic            iack_o,
  input logic            take,
  input logic            ret,
  input logic [XLEN-1:0] mask
);
  // R4: mask pushes one nibble on entry
  assert_entry_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> mask == ($past(mask) << 4));
  // R4: entry always goes to the vector
  assert_entry_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (redirect_o && target_o == VECTOR));
  // R7: return pops one nibble
  assert_return_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret |=> mask == ($past(mask) >> 4));
  // R9: upper reason bits read zero
  assert_reason_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr_i == 5'd13) |-> (csr_rdata_o[XLEN-1:2] == '0));
  // R5, R3: acknowledge needs an enabled request at a boundary
  assert_iack_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |-> (irq_i && step_done_i && mask[3]));
  // R6: acknowledge lasts one cycle
  assert_iack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |=> !iack_o);
  // R2: an enabled overflow always wins the redirect
  assert_ovf_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i && mask[1]) |-> (redirect_o && !iack_o && target_o == VECTOR));
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN), .AW(AW), .VECTOR(VECTOR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_done_i (step_done_i),
  .ovf_i       (ovf_i),
  .irq_i       (irq_i),
  .csr_addr_i  (csr_addr_i),
  .csr_rdata_o (csr_rdata_o),
  .redirect_o  (redirect_o),
  .target_o    (target_o),
  .iack_o      (iack_o),
  .take        (take_w),
  .ret         (ret_w),
  .mask        (mask_w)
);

// File: tb/trap_unit_bench.sv
module trap_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic        step_done_i = 1'b0, ovf_i = 1'b0, bad_op_i = 1'b0, sys_i = 1'b0;
  logic        irq_i = 1'b0, eret_i = 1'b0, csr_we_i = 1'b0;
  logic [4:0]  csr_addr_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o, target_o;
  logic        redirect_o, iack_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string       tag;
    logic        redir;
    logic [31:0] tgt;
    logic        ack;
    logic [31:0] rd;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  trap_unit u_trap_unit (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .step_done_i(step_done_i),
    .ovf_i(ovf_i), .bad_op_i(bad_op_i), .sys_i(sys_i), .irq_i(irq_i),
    .eret_i(eret_i), .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .redirect_o(redirect_o), .target_o(target_o), .iack_o(iack_o)
  );

  // Driver: ev = {ovf,bad,sys,irq,done,eret}
  task automatic step(input string tag, input logic [31:0] pc, input logic [5:0] ev,
                      input logic we, input logic [4:0] addr, input logic [31:0] wd,
                      input logic x_redir, input logic [31:0] x_tgt,
                      input logic x_ack, input logic [31:0] x_rd);
    exp_t e;
    @(negedge clk);
    pc_i = pc;
    {ovf_i, bad_op_i, sys_i, irq_i, step_done_i, eret_i} = ev;
    csr_we_i = we; csr_addr_i = addr; csr_wdata_i = wd;
    e.tag = tag; e.redir = x_redir; e.tgt = x_tgt; e.ack = x_ack; e.rd = x_rd;
    sb.push_back(e);
  endtask

  // Monitor: compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (redirect_o !== e.redir || target_o !== e.tgt ||
            iack_o !== e.ack || csr_rdata_o !== e.rd) begin
          errors++;
          $display("FAIL %s: got redir=%0b tgt=%h ack=%0b rd=%h, expected redir=%0b tgt=%h ack=%0b rd=%h",
                   e.tag, redirect_o, target_o, iack_o, csr_rdata_o,
                   e.redir, e.tgt, e.ack, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset values
    step("R1 mask",   32'h0, 6'b000000, 0, 5'd12, 0, 0, 32'h0, 0, 32'hF);
    step("R1 reason", 32'h0, 6'b000000, 0, 5'd13, 0, 0, 32'h0, 0, 32'h0);
    step("R1 save",   32'h0, 6'b000000, 0, 5'd14, 0, 0, 32'h0, 0, 32'h0);
    // R2 all four at once: overflow wins; R4 entry
    step("R2 all pending", 32'h100, 6'b111110, 0, 5'd13, 0, 1, 32'h4, 0, 32'h0);
    step("R4 reason ovf", 32'h0, 6'b000000, 0, 5'd13, 0, 0, 32'h100, 0, 32'h2);
    step("R4 save pc",    32'h0, 6'b000000, 0, 5'd14, 0, 0, 32'h100, 0, 32'h100);
    step("R4 mask push",  32'h0, 6'b000000, 0, 5'd12, 0, 0, 32'h100, 0, 32'hF0);
    // R3 everything masked
    step("R3 masked", 32'h180, 6'b111110, 0, 5'd13, 0, 0, 32'h100, 0, 32'h2);
    step("R3 save kept", 32'h0, 6'b000000, 0, 5'd14, 0, 0, 32'h100, 0, 32'h100);
    // R7 return
    step("R7 return", 32'h0, 6'b000001, 0, 5'd12, 0, 1, 32'h100, 0, 32'hF0);
    step("R7 mask pop", 32'h0, 6'b000000, 0, 5'd12, 0, 0, 32'h100, 0, 32'hF);
    // R5 held request waits for boundary; R6 pulse
    step("R5 no strobe", 32'h200, 6'b000100, 0, 5'd13, 0, 0, 32'h100, 0, 32'h2);
    step("R5 no strobe 2", 32'h200, 6'b000100, 0, 5'd13, 0, 0, 32'h100, 0, 32'h2);
    step("R6 irq taken", 32'h200, 6'b000110, 0, 5'd13, 0, 1, 32'h4, 1, 32'h2);
    step("R6 ack drops", 32'h204, 6'b000110, 0, 5'd13, 0, 0, 32'h200, 0, 32'h0);
    step("R4 irq save", 32'h0, 6'b000000, 0, 5'd14, 0, 0, 32'h200, 0, 32'h200);
    step("R7 return 2", 32'h0, 6'b000001, 0, 5'd12, 0, 1, 32'h200, 0, 32'hF0);
    // R3 partial mask: only invalid instruction enabled
    step("R8 write mask", 32'h0, 6'b000000, 1, 5'd12, 32'h4, 0, 32'h200, 0, 32'hF);
    step("R3 ovf masked", 32'h300, 6'b111000, 0, 5'd12, 0, 1, 32'h4, 0, 32'h4);
    step("R4 reason bad", 32'h0, 6'b000000, 0, 5'd13, 0, 0, 32'h300, 0, 32'h1);
    step("R4 mask 40", 32'h0, 6'b000000, 0, 5'd12, 0, 0, 32'h300, 0, 32'h40);
    // R8 register port
    step("R8 write save", 32'h0, 6'b000000, 1, 5'd14, 32'hABC, 0, 32'h300, 0, 32'h300);
    step("R8 read save", 32'h0, 6'b000000, 0, 5'd14, 0, 0, 32'hABC, 0, 32'hABC);
    step("R8 write unused", 32'h0, 6'b000000, 1, 5'd20, 32'hFFFF_FFFF, 0, 32'hABC, 0, 32'h0);
    step("R8 unused reads 0", 32'h0, 6'b000000, 0, 5'd20, 0, 0, 32'hABC, 0, 32'h0);
    step("R8 mask intact", 32'h0, 6'b000000, 0, 5'd12, 0, 0, 32'hABC, 0, 32'h40);
    step("R8 reason intact", 32'h0, 6'b000000, 0, 5'd13, 0, 0, 32'hABC, 0, 32'h1);
    step("R7 return to write", 32'h0, 6'b000001, 0, 5'd12, 0, 1, 32'hABC, 0, 32'h40);
    step("R8 mask sys", 32'h0, 6'b000000, 1, 5'd12, 32'h1, 0, 32'hABC, 0, 32'h4);
    step("R4 sys taken", 32'h400, 6'b001000, 0, 5'd13, 0, 1, 32'h4, 0, 32'h1);
    step("R4 reason sys", 32'h0, 6'b000000, 0, 5'd13, 0, 0, 32'h400, 0, 32'h3);
    // R9 upper reason bits
    step("R9 write ones", 32'h0, 6'b000000, 1, 5'd13, 32'hFFFF_FFFF, 0, 32'h400, 0, 32'h3);
    step("R9 reads 3", 32'h0, 6'b000000, 0, 5'd13, 0, 0, 32'h400, 0, 32'h3);
    step("R9 write 0", 32'h0, 6'b000000, 1, 5'd13, 32'h0, 0, 32'h400, 0, 32'h3);
    step("R9 reads 0", 32'h0, 6'b000000, 0, 5'd13, 0, 0, 32'h400, 0, 32'h0);
    // R10 event beats write and return
    step("R10 mask F", 32'h0, 6'b000000, 1, 5'd12, 32'hF, 0, 32'h400, 0, 32'h10);
    step("R10 sys+wr+ret", 32'h500, 6'b001001, 1, 5'd12, 32'h0, 1, 32'h4, 0, 32'hF);
    step("R10 mask pushed", 32'h0, 6'b000000, 0, 5'd12, 0, 0, 32'h500, 0, 32'hF0);
    step("R10 save pc", 32'h0, 6'b000000, 0, 5'd14, 0, 0, 32'h500, 0, 32'h500);
    // R2 syscall before interrupt
    step("R7 return 3", 32'h0, 6'b000001, 0, 5'd12, 0, 1, 32'h500, 0, 32'hF0);
    step("R2 sys over irq", 32'h600, 6'b001110, 0, 5'd13, 0, 1, 32'h4, 0, 32'h3);
    step("R2 reason sys", 32'h0, 6'b000000, 0, 5'd13, 0, 0, 32'h600, 0, 32'h3);
    step("R2 bad over sys", 32'h0, 6'b000001, 0, 5'd12, 0, 1, 32'h600, 0, 32'hF0);
    step("R2 bad taken", 32'h700, 6'b011110, 0, 5'd13, 0, 1, 32'h4, 0, 32'h3);
    step("R2 reason bad", 32'h0, 6'b000000, 0, 5'd13, 0, 0, 32'h700, 0, 32'h1);
    @(negedge clk);
    @(negedge clk);
    #5;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule